// File: doc/BRIEF.md
# Card Configuration Tuple Parser

This block walks a stream of card configuration tuples one byte per cycle and fills a register file of board parameters: two MAC address copies, revision and board-revision bytes, a vendor identifier, three power-amplifier coefficients, idle-TSSI and maximum-power bytes, a country byte, antenna and antenna-gain bytes, board-flag words and a four-entry LED/GPIO map. A controller pulses `start`, which loads defaults, and then pushes the tuples. The block recognises the extended-function tuple that carries a node address and one vendor tuple whose first data byte selects a subcode. It validates the declared size of each recognised tuple and packs the data bytes into fields as they arrive.

The walk is a state machine with seven states. `IDLE` waits; `start` from any state goes to `CODE`. `CODE` takes the tuple code byte: the end code goes to `DONE`, any other code goes to `SIZE` (or stays in `CODE` if that byte also ends the tuple). `SIZE` stores the declared size and goes to `SUB`, or back to `CODE` when the tuple has no data. `SUB` takes data byte 0 (the subcode), checks the size and goes to `FAIL` on a violation, to `CODE` at the end of the tuple, or to `BODY`. `BODY` takes the remaining data bytes, writes fields, goes to `FAIL` on a bad node-address length and to `CODE` at the end of the tuple. `DONE` lasts one cycle and returns to `IDLE`. `FAIL` holds until the next `start`.

Top module: `tuple_cfg_parser`

## Requirements
- R1: After reset and in the cycle after `start`, every parameter output is all ones except `flags_lo` and `flags_hi`, which are zero; after reset `busy`, `done` and `err` are low and `err_code` is 0.
- R2: Each tuple is a code byte, a declared-size byte and its data bytes, one byte per cycle with `in_valid` high; `in_last` marks the final byte of each tuple and the stream is never framed by the size byte. Code 0xFF in the code position ends the parse: `done` is high for exactly one cycle after that byte is taken and `busy` then drops.
- R3: A tuple with code 0x22 whose data byte 0 is 0x04 carries the node address in data bytes 2 to 7; both `mac_pri` and `mac_sec` receive it, data byte 2 in bits 47:40 and data byte 7 in bits 7:0.
- R4: That node-address tuple fails only when its declared size is not 7 and its data byte 1 is also not 6; the failure reports `err_code` 1.
- R5: In a code-0x80 tuple, subcodes 0x00 (`srom_rev`), 0x02 (`board_rev`), 0x05 (`country`), 0x06 (`ant_a` and `ant_g`) and 0x07 (all eight bytes of `ant_gain`) require size 2 and take data byte 1.
- R6: Subcode 0x01 accepts size 5 or 7 and sets `vendor_id` to data byte 1 in bits 7:0 and data byte 2 in bits 15:8.
- R7: Subcode 0x03 accepts size 9 or 10; coefficients 0, 1, 2 (`pa_coef` bits 15:0, 31:16, 47:32) are little-endian from data bytes 1-2, 3-4 and 5-6; byte 7 goes to both idle-TSSI outputs and byte 8 to both max-power outputs.
- R8: Subcode 0x08 accepts size 3 or 5 and sets `flags_lo` little-endian from data bytes 1 and 2; subcode 0x09 requires size 5 and puts data bytes 1 to 4 into `led_map` bits 7:0, 15:8, 23:16 and 31:24.
- R9: A size violation stops the parse: `err` rises and stays high until the next `start`, `err_code` is the subcode plus 2, later bytes (including the end code) change no field and raise no `done`.
- R10: Unknown tuple codes, vendor subcodes above 0x09 and vendor subcode 0x04 are skipped with no error and no field change.
- R11: `start` wins over a byte offered in the same cycle: that byte is dropped, and `err` and `err_code` clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a parse and load defaults |
| in_valid | input | 1 | Stream byte valid |
| in_data | input | 8 | Stream byte |
| in_last | input | 1 | Final byte of the current tuple |
| busy | output | 1 | Parse in progress |
| done | output | 1 | One-cycle pulse after the end code |
| err | output | 1 | Sticky parse failure |
| err_code | output | 4 | Failure number |
| mac_pri | output | 48 | Primary node address |
| mac_sec | output | 48 | Secondary node address |
| srom_rev | output | 8 | Parameter-store revision |
| vendor_id | output | 16 | Board vendor identifier |
| board_rev | output | 8 | Board revision |
| pa_coef | output | 48 | Three 16-bit power-amplifier coefficients |
| idle_tssi_a | output | 8 | Idle TSSI, 5 GHz band |
| idle_tssi_g | output | 8 | Idle TSSI, 2.4 GHz band |
| max_pwr_a | output | 8 | Maximum power, 5 GHz band |
| max_pwr_g | output | 8 | Maximum power, 2.4 GHz band |
| country | output | 8 | Country byte |
| ant_a | output | 8 | Antenna availability, 5 GHz band |
| ant_g | output | 8 | Antenna availability, 2.4 GHz band |
| ant_gain | output | 64 | Eight antenna-gain bytes, four per band |
| flags_lo | output | 16 | Board flags, low word |
| flags_hi | output | 16 | Board flags, high word |
| led_map | output | 32 | Four LED/GPIO bytes |

## Verification
Two functions meet in one cycle when `start` is raised while a byte is offered on the stream, and when a size violation falls on the byte that also ends its tuple. The bench offers the end code together with `start` after a failed parse and judges that `err` clears, `busy` rises and no `done` follows, so the byte was dropped. It also sends a short subcode tuple whose subcode byte carries `in_last` and judges that the failure is reported and the following end code produces no `done`.

// File: rtl/tcp_pkg.sv
package tcp_pkg;
    localparam int BYTE_W    = 8;
    localparam int MAC_BYTES = 6;
    localparam int COEF_CNT  = 3;
    localparam int COEF_W    = 16;
    localparam int GPIO_CNT  = 4;
    localparam int GAIN_CNT  = 8;
    localparam int ERR_W     = 4;
    localparam int MAC_W     = BYTE_W * MAC_BYTES;

    typedef enum logic [2:0] {
        ST_IDLE, ST_CODE, ST_SIZE, ST_SUB, ST_BODY, ST_DONE, ST_FAIL
    } walk_state_t;

    typedef enum logic [3:0] {
        K_SKIP, K_MAC, K_REV, K_ID, K_BREV, K_PA,
        K_CCODE, K_ANT, K_GAIN, K_BFL, K_LED
    } tuple_kind_t;

    typedef struct packed {
        logic [MAC_W-1:0]                     mac_pri;
        logic [MAC_W-1:0]                     mac_sec;
        logic [BYTE_W-1:0]                    srom_rev;
        logic [2*BYTE_W-1:0]                  vendor_id;
        logic [BYTE_W-1:0]                    board_rev;
        logic [COEF_CNT-1:0][COEF_W-1:0]      pa_coef;
        logic [BYTE_W-1:0]                    idle_tssi_a;
        logic [BYTE_W-1:0]                    idle_tssi_g;
        logic [BYTE_W-1:0]                    max_pwr_a;
        logic [BYTE_W-1:0]                    max_pwr_g;
        logic [BYTE_W-1:0]                    country;
        logic [BYTE_W-1:0]                    ant_a;
        logic [BYTE_W-1:0]                    ant_g;
        logic [GAIN_CNT-1:0][BYTE_W-1:0]      ant_gain;
        logic [2*BYTE_W-1:0]                  flags_lo;
        logic [2*BYTE_W-1:0]                  flags_hi;
        logic [GPIO_CNT-1:0][BYTE_W-1:0]      led_map;
    } board_params_t;

    function automatic board_params_t param_defaults();
        board_params_t p;
        p          = '1;
        p.flags_lo = '0;
        p.flags_hi = '0;
        return p;
    endfunction
endpackage

// File: rtl/tcp_rule_check.sv
module tcp_rule_check
    import tcp_pkg::*;
#(
    parameter logic [BYTE_W-1:0] EXT_CODE  = 8'h22,
    parameter logic [BYTE_W-1:0] VEND_CODE = 8'h80,
    parameter logic [BYTE_W-1:0] NODE_SUB  = 8'h04,
    parameter logic [BYTE_W-1:0] NODE_LEN  = 8'd6,
    parameter logic [BYTE_W-1:0] NODE_SIZE = 8'd7
) (
    input  logic [BYTE_W-1:0] code_q,
    input  logic [BYTE_W-1:0] size_q,
    input  logic [BYTE_W-1:0] cur_byte,
    output tuple_kind_t       kind,
    output logic              sub_size_ok,
    output logic              mac_len_ok,
    output logic [ERR_W-1:0]  sub_err
);
    localparam int ERR_BIAS  = 2;
    localparam int SUB_LIMIT = 16;

    // Kind of the tuple, decided on data byte 0
    always_comb begin
        kind = K_SKIP;
        if (code_q == EXT_CODE && cur_byte == NODE_SUB) begin
            kind = K_MAC;
        end else if (code_q == VEND_CODE && cur_byte < BYTE_W'(SUB_LIMIT)) begin
            case (cur_byte[3:0])
                4'd0:    kind = K_REV;
                4'd1:    kind = K_ID;
                4'd2:    kind = K_BREV;
                4'd3:    kind = K_PA;
                4'd5:    kind = K_CCODE;
                4'd6:    kind = K_ANT;
                4'd7:    kind = K_GAIN;
                4'd8:    kind = K_BFL;
                4'd9:    kind = K_LED;
                default: kind = K_SKIP;
            endcase
        end
    end

    // Allowed declared sizes per subcode
    always_comb begin
        case (kind)
            K_REV, K_BREV, K_CCODE, K_ANT, K_GAIN:
                     sub_size_ok = (size_q == BYTE_W'(2));
            K_ID:    sub_size_ok = (size_q == BYTE_W'(5)) || (size_q == BYTE_W'(7));
            K_PA:    sub_size_ok = (size_q == BYTE_W'(9)) || (size_q == BYTE_W'(10));
            K_BFL:   sub_size_ok = (size_q == BYTE_W'(3)) || (size_q == BYTE_W'(5));
            K_LED:   sub_size_ok = (size_q == BYTE_W'(5));
            default: sub_size_ok = 1'b1;
        endcase
    end

    // Node-address tuple fails only when both size and length byte disagree
    assign mac_len_ok = (size_q == NODE_SIZE) || (cur_byte == NODE_LEN);
    assign sub_err    = cur_byte[ERR_W-1:0] + ERR_W'(ERR_BIAS);
endmodule

// File: rtl/tcp_walker.sv
module tcp_walker
    import tcp_pkg::*;
#(
    parameter logic [BYTE_W-1:0] END_CODE = 8'hFF,
    parameter logic [ERR_W-1:0]  ERR_MAC  = 4'd1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_last,
    input  tuple_kind_t       kind_now,
    input  logic              sub_size_ok,
    input  logic              mac_len_ok,
    input  logic [ERR_W-1:0]  sub_err,
    output logic [BYTE_W-1:0] code_q,
    output logic [BYTE_W-1:0] size_q,
    output logic              wr_en,
    output tuple_kind_t       wr_kind,
    output logic [BYTE_W-1:0] wr_idx,
    output logic              load,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [ERR_W-1:0]  err_code
);
    walk_state_t       st, st_n;
    tuple_kind_t       kind_q, kind_n;
    logic [BYTE_W-1:0] code_n, size_n, idx, idx_n;
    logic [ERR_W-1:0]  ecode, ecode_n;
    logic              vend_kind;

    assign vend_kind = (kind_now != K_SKIP) && (kind_now != K_MAC);

    // Next state
    always_comb begin
        st_n    = st;
        code_n  = code_q;
        size_n  = size_q;
        idx_n   = idx;
        kind_n  = kind_q;
        ecode_n = ecode;
        wr_en   = 1'b0;
        if (start) begin
            st_n    = ST_CODE;
            ecode_n = '0;
        end else begin
            unique case (st)
                ST_IDLE: ;
                ST_DONE: st_n = ST_IDLE;
                ST_FAIL: ;
                ST_CODE: if (in_valid) begin
                    if (in_data == END_CODE) begin
                        st_n = ST_DONE;
                    end else begin
                        code_n = in_data;
                        st_n   = in_last ? ST_CODE : ST_SIZE;
                    end
                end
                ST_SIZE: if (in_valid) begin
                    size_n = in_data;
                    st_n   = in_last ? ST_CODE : ST_SUB;
                end
                ST_SUB: if (in_valid) begin
                    kind_n = kind_now;
                    idx_n  = BYTE_W'(1);
                    if (vend_kind && !sub_size_ok) begin
                        st_n    = ST_FAIL;
                        ecode_n = sub_err;
                    end else begin
                        st_n = in_last ? ST_CODE : ST_BODY;
                    end
                end
                ST_BODY: if (in_valid) begin
                    idx_n = idx + BYTE_W'(1);
                    if (kind_q == K_MAC && idx == BYTE_W'(1) && !mac_len_ok) begin
                        st_n    = ST_FAIL;
                        ecode_n = ERR_MAC;
                    end else begin
                        wr_en = 1'b1;
                        st_n  = in_last ? ST_CODE : ST_BODY;
                    end
                end
                default: st_n = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st     <= ST_IDLE;
            code_q <= '0;
            size_q <= '0;
            idx    <= '0;
            kind_q <= K_SKIP;
            ecode  <= '0;
        end else begin
            st     <= st_n;
            code_q <= code_n;
            size_q <= size_n;
            idx    <= idx_n;
            kind_q <= kind_n;
            ecode  <= ecode_n;
        end
    end

    // Outputs
    always_comb begin
        busy     = (st == ST_CODE) || (st == ST_SIZE) || (st == ST_SUB) || (st == ST_BODY);
        done     = (st == ST_DONE);
        err      = (st == ST_FAIL);
        err_code = ecode;
        load     = start;
        wr_kind  = kind_q;
        wr_idx   = idx;
    end

    p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_fail_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !start) |=> err);
    p_fail_code_r9: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (err_code != '0));
    p_size_abort_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SUB && in_valid && !start && vend_kind && !sub_size_ok) |=> err);
    p_mac_abort_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_BODY && in_valid && !start && kind_q == K_MAC && idx == BYTE_W'(1) && !mac_len_ok)
        |=> (err && err_code == ERR_MAC));
    p_start_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (busy && !err && err_code == '0));
endmodule

// File: rtl/tcp_field_file.sv
module tcp_field_file
    import tcp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              wr_en,
    input  tuple_kind_t       wr_kind,
    input  logic [BYTE_W-1:0] wr_idx,
    input  logic [BYTE_W-1:0] wr_byte,
    output board_params_t     params
);
    localparam int MAC_FIRST  = 2;
    localparam int LED_FIRST  = 1;
    localparam int TSSI_IDX   = 2 * COEF_CNT + 1;
    localparam int MAXP_IDX   = TSSI_IDX + 1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            params <= param_defaults();
        end else if (load) begin
            params <= param_defaults();
        end else if (wr_en) begin
            case (wr_kind)
                K_MAC: for (int b = 0; b < MAC_BYTES; b++) begin
                    if (wr_idx == BYTE_W'(b + MAC_FIRST)) begin
                        params.mac_pri[BYTE_W*(MAC_BYTES-1-b) +: BYTE_W] <= wr_byte;
                        params.mac_sec[BYTE_W*(MAC_BYTES-1-b) +: BYTE_W] <= wr_byte;
                    end
                end
                K_REV:   if (wr_idx == BYTE_W'(1)) params.srom_rev  <= wr_byte;
                K_BREV:  if (wr_idx == BYTE_W'(1)) params.board_rev <= wr_byte;
                K_CCODE: if (wr_idx == BYTE_W'(1)) params.country   <= wr_byte;
                K_ANT: if (wr_idx == BYTE_W'(1)) begin
                    params.ant_a <= wr_byte;
                    params.ant_g <= wr_byte;
                end
                K_GAIN: if (wr_idx == BYTE_W'(1)) params.ant_gain <= {GAIN_CNT{wr_byte}};
                K_ID: begin
                    if (wr_idx == BYTE_W'(1)) params.vendor_id[BYTE_W-1:0]      <= wr_byte;
                    if (wr_idx == BYTE_W'(2)) params.vendor_id[2*BYTE_W-1:BYTE_W] <= wr_byte;
                end
                K_PA: begin
                    for (int c = 0; c < COEF_CNT; c++) begin
                        if (wr_idx == BYTE_W'(2*c + 1)) params.pa_coef[c][BYTE_W-1:0]      <= wr_byte;
                        if (wr_idx == BYTE_W'(2*c + 2)) params.pa_coef[c][COEF_W-1:BYTE_W] <= wr_byte;
                    end
                    if (wr_idx == BYTE_W'(TSSI_IDX)) begin
                        params.idle_tssi_a <= wr_byte;
                        params.idle_tssi_g <= wr_byte;
                    end
                    if (wr_idx == BYTE_W'(MAXP_IDX)) begin
                        params.max_pwr_a <= wr_byte;
                        params.max_pwr_g <= wr_byte;
                    end
                end
                K_BFL: begin
                    if (wr_idx == BYTE_W'(1)) params.flags_lo[BYTE_W-1:0]        <= wr_byte;
                    if (wr_idx == BYTE_W'(2)) params.flags_lo[2*BYTE_W-1:BYTE_W] <= wr_byte;
                end
                K_LED: for (int g = 0; g < GPIO_CNT; g++) begin
                    if (wr_idx == BYTE_W'(g + LED_FIRST)) params.led_map[g] <= wr_byte;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/tuple_cfg_parser.sv
module tuple_cfg_parser
    import tcp_pkg::*;
#(
    parameter logic [BYTE_W-1:0] EXT_CODE  = 8'h22,
    parameter logic [BYTE_W-1:0] VEND_CODE = 8'h80,
    parameter logic [BYTE_W-1:0] END_CODE  = 8'hFF,
    parameter logic [BYTE_W-1:0] NODE_SUB  = 8'h04
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start,
    input  logic                       in_valid,
    input  logic [BYTE_W-1:0]          in_data,
    input  logic                       in_last,
    output logic                       busy,
    output logic                       done,
    output logic                       err,
    output logic [ERR_W-1:0]           err_code,
    output logic [MAC_W-1:0]           mac_pri,
    output logic [MAC_W-1:0]           mac_sec,
    output logic [BYTE_W-1:0]          srom_rev,
    output logic [2*BYTE_W-1:0]        vendor_id,
    output logic [BYTE_W-1:0]          board_rev,
    output logic [COEF_CNT*COEF_W-1:0] pa_coef,
    output logic [BYTE_W-1:0]          idle_tssi_a,
    output logic [BYTE_W-1:0]          idle_tssi_g,
    output logic [BYTE_W-1:0]          max_pwr_a,
    output logic [BYTE_W-1:0]          max_pwr_g,
    output logic [BYTE_W-1:0]          country,
    output logic [BYTE_W-1:0]          ant_a,
    output logic [BYTE_W-1:0]          ant_g,
    output logic [GAIN_CNT*BYTE_W-1:0] ant_gain,
    output logic [2*BYTE_W-1:0]        flags_lo,
    output logic [2*BYTE_W-1:0]        flags_hi,
    output logic [GPIO_CNT*BYTE_W-1:0] led_map
);
    logic [BYTE_W-1:0] code_q, size_q, wr_idx;
    tuple_kind_t       kind_now, wr_kind;
    logic              sub_size_ok, mac_len_ok, wr_en, load;
    logic [ERR_W-1:0]  sub_err;
    board_params_t     params;

    tcp_rule_check #(
        .EXT_CODE (EXT_CODE),
        .VEND_CODE(VEND_CODE),
        .NODE_SUB (NODE_SUB)
    ) u_rules (
        .code_q     (code_q),
        .size_q     (size_q),
        .cur_byte   (in_data),
        .kind       (kind_now),
        .sub_size_ok(sub_size_ok),
        .mac_len_ok (mac_len_ok),
        .sub_err    (sub_err)
    );

    tcp_walker #(
        .END_CODE(END_CODE)
    ) u_walk (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .in_valid   (in_valid),
        .in_data    (in_data),
        .in_last    (in_last),
        .kind_now   (kind_now),
        .sub_size_ok(sub_size_ok),
        .mac_len_ok (mac_len_ok),
        .sub_err    (sub_err),
        .code_q     (code_q),
        .size_q     (size_q),
        .wr_en      (wr_en),
        .wr_kind    (wr_kind),
        .wr_idx     (wr_idx),
        .load       (load),
        .busy       (busy),
        .done       (done),
        .err        (err),
        .err_code   (err_code)
    );

    tcp_field_file u_fields (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (load),
        .wr_en  (wr_en),
        .wr_kind(wr_kind),
        .wr_idx (wr_idx),
        .wr_byte(in_data),
        .params (params)
    );

    assign mac_pri     = params.mac_pri;
    assign mac_sec     = params.mac_sec;
    assign srom_rev    = params.srom_rev;
    assign vendor_id   = params.vendor_id;
    assign board_rev   = params.board_rev;
    assign pa_coef     = params.pa_coef;
    assign idle_tssi_a = params.idle_tssi_a;
    assign idle_tssi_g = params.idle_tssi_g;
    assign max_pwr_a   = params.max_pwr_a;
    assign max_pwr_g   = params.max_pwr_g;
    assign country     = params.country;
    assign ant_a       = params.ant_a;
    assign ant_g       = params.ant_g;
    assign ant_gain    = params.ant_gain;
    assign flags_lo    = params.flags_lo;
    assign flags_hi    = params.flags_hi;
    assign led_map     = params.led_map;

    p_defaults_r1: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (flags_lo == '0 && flags_hi == '0 && srom_rev == '1 && mac_pri == '1));
    p_fail_freeze_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !start) |=> $stable(params));
    p_idle_freeze_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(params));
endmodule

// File: tb/tuple_cfg_parser_tb.sv
module tuple_cfg_parser_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = 8'h00;
    logic        in_last = 1'b0;
    logic        busy, done, err;
    logic [3:0]  err_code;
    logic [47:0] mac_pri, mac_sec;
    logic [7:0]  srom_rev, board_rev, idle_tssi_a, idle_tssi_g, max_pwr_a, max_pwr_g;
    logic [7:0]  country, ant_a, ant_g;
    logic [15:0] vendor_id, flags_lo, flags_hi;
    logic [47:0] pa_coef;
    logic [63:0] ant_gain;
    logic [31:0] led_map;
    int tests = 0;
    int failed = 0;

    always #10 clk = ~clk;

    tuple_cfg_parser u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid),
        .in_data(in_data), .in_last(in_last), .busy(busy), .done(done),
        .err(err), .err_code(err_code), .mac_pri(mac_pri), .mac_sec(mac_sec),
        .srom_rev(srom_rev), .vendor_id(vendor_id), .board_rev(board_rev),
        .pa_coef(pa_coef), .idle_tssi_a(idle_tssi_a), .idle_tssi_g(idle_tssi_g),
        .max_pwr_a(max_pwr_a), .max_pwr_g(max_pwr_g), .country(country),
        .ant_a(ant_a), .ant_g(ant_g), .ant_gain(ant_gain), .flags_lo(flags_lo),
        .flags_hi(flags_hi), .led_map(led_map)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            failed++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, input logic l);
        in_valid = 1'b1;
        in_data  = b;
        in_last  = l;
        @(negedge clk);
        in_valid = 1'b0;
        in_last  = 1'b0;
    endtask

    // d holds data byte i at bits [8*i +: 8]
    task automatic send_tuple(input logic [7:0] code, input logic [7:0] size,
                              input int n, input logic [127:0] d);
        send_byte(code, 1'b0);
        send_byte(size, n == 0);
        for (int i = 0; i < n; i++) send_byte(d[8*i +: 8], i == n - 1);
    endtask

    task automatic do_start();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 reset busy", 64'(busy), 64'd0);
        chk("R1 reset done", 64'(done), 64'd0);
        chk("R1 reset err", 64'(err), 64'd0);
        chk("R1 reset err_code", 64'(err_code), 64'd0);
        chk("R1 reset srom_rev", 64'(srom_rev), 64'hFF);
        chk("R1 reset flags_lo", 64'(flags_lo), 64'd0);
    endtask

    task automatic t_defaults();
        do_start();
        chk("R1 start busy", 64'(busy), 64'd1);
        chk("R1 default mac_pri", 64'(mac_pri), 64'hFFFF_FFFF_FFFF);
        chk("R1 default led_map", 64'(led_map), 64'hFFFF_FFFF);
        chk("R1 default flags_hi", 64'(flags_hi), 64'd0);
        chk("R1 default ant_gain", ant_gain, 64'hFFFF_FFFF_FFFF_FFFF);
    endtask

    task automatic t_good_chain();
        do_start();
        send_tuple(8'h80, 8'd2, 2, 128'h11_00);
        send_tuple(8'h80, 8'd5, 5, 128'hBB_AA_12_34_01);
        send_tuple(8'h80, 8'd2, 2, 128'h21_02);
        send_tuple(8'h80, 8'd10, 10, 128'hEE_4D_3C_06_05_04_03_02_01_03);
        send_tuple(8'h80, 8'd2, 2, 128'h55_05);
        send_tuple(8'h80, 8'd2, 2, 128'h03_06);
        send_tuple(8'h80, 8'd2, 2, 128'h09_07);
        send_tuple(8'h80, 8'd5, 5, 128'h88_77_AB_CD_08);
        send_tuple(8'h80, 8'd5, 5, 128'hA4_A3_A2_A1_09);
        send_tuple(8'h22, 8'd7, 8, 128'h55_44_33_22_11_00_06_04);
        send_tuple(8'h15, 8'd3, 3, 128'h03_02_01);      // R10 unknown code
        send_tuple(8'h80, 8'd3, 3, 128'h98_99_04);      // R10 ignored subcode
        send_tuple(8'h80, 8'd2, 2, 128'h66_0C);         // R10 unknown subcode
        chk("R2 busy before end", 64'(busy), 64'd1);
        send_byte(8'hFF, 1'b0);
        chk("R2 done pulse", 64'(done), 64'd1);
        chk("R10 no error", 64'(err), 64'd0);
        chk("R5 srom_rev", 64'(srom_rev), 64'h11);
        chk("R6 vendor_id", 64'(vendor_id), 64'h1234);
        chk("R5 board_rev", 64'(board_rev), 64'h21);
        chk("R7 pa_coef", 64'(pa_coef), 64'h0605_0403_0201);
        chk("R7 tssi", 64'({idle_tssi_a, idle_tssi_g}), 64'h3C3C);
        chk("R7 maxpwr", 64'({max_pwr_a, max_pwr_g}), 64'h4D4D);
        chk("R5 country", 64'(country), 64'h55);
        chk("R5 antenna", 64'({ant_a, ant_g}), 64'h0303);
        chk("R5 ant_gain", ant_gain, 64'h0909_0909_0909_0909);
        chk("R8 flags_lo", 64'(flags_lo), 64'hABCD);
        chk("R8 flags_hi", 64'(flags_hi), 64'h0000);
        chk("R8 led_map", 64'(led_map), 64'hA4A3_A2A1);
        chk("R3 mac_pri", 64'(mac_pri), 64'h0011_2233_4455);
        chk("R3 mac_sec", 64'(mac_sec), 64'h0011_2233_4455);
        @(negedge clk);
        chk("R2 done single cycle", 64'(done), 64'd0);
        chk("R2 busy dropped", 64'(busy), 64'd0);
    endtask

    task automatic t_mac_rule();
        do_start();
        send_tuple(8'h22, 8'd8, 9, 128'h00_A5_A4_A3_A2_A1_A0_06_04);
        chk("R4 size 8 len 6 accepted", 64'(mac_pri), 64'hA0A1_A2A3_A4A5);
        send_tuple(8'h22, 8'd7, 8, 128'hB5_B4_B3_B2_B1_B0_05_04);
        chk("R4 size 7 len 5 accepted", 64'(mac_sec), 64'hB0B1_B2B3_B4B5);
        chk("R4 no error", 64'(err), 64'd0);
        do_start();
        send_tuple(8'h22, 8'd8, 9, 128'h00_C5_C4_C3_C2_C1_C0_05_04);
        send_byte(8'hFF, 1'b0);
        chk("R4 error raised", 64'(err), 64'd1);
        chk("R4 error code", 64'(err_code), 64'd1);
        chk("R4 mac untouched", 64'(mac_pri), 64'hFFFF_FFFF_FFFF);
        chk("R9 no done after fail", 64'(done), 64'd0);
    endtask

    task automatic t_bad_size(input logic [7:0] sub, input logic [7:0] size, input int n,
                              input logic [127:0] d, input logic [3:0] exp_code);
        do_start();
        send_tuple(8'h80, 8'd2, 2, 128'h42_00);
        send_tuple(8'h80, size, n, d | 128'(sub));
        send_tuple(8'h80, 8'd2, 2, 128'h77_05);
        send_byte(8'hFF, 1'b0);
        chk("R9 err", 64'(err), 64'd1);
        chk("R9 err_code", 64'(err_code), 64'(exp_code));
        chk("R9 done suppressed", 64'(done), 64'd0);
        chk("R9 later tuple ignored", 64'(country), 64'hFF);
        chk("R9 earlier tuple kept", 64'(srom_rev), 64'h42);
    endtask

    task automatic t_fail_on_last();
        do_start();
        send_tuple(8'h80, 8'd8, 1, 128'h03);   // PA subcode byte is the tuple end
        chk("R9 fail on tuple end", 64'(err), 64'd1);
        chk("R9 fail code PA", 64'(err_code), 64'd5);
        send_byte(8'hFF, 1'b0);
        chk("R9 no done on end after fail", 64'(done), 64'd0);
    endtask

    task automatic t_start_collide();
        start    = 1'b1;
        in_valid = 1'b1;
        in_data  = 8'hFF;
        @(negedge clk);
        start    = 1'b0;
        in_valid = 1'b0;
        chk("R11 err cleared", 64'(err), 64'd0);
        chk("R11 err_code cleared", 64'(err_code), 64'd0);
        chk("R11 busy", 64'(busy), 64'd1);
        @(negedge clk);
        chk("R11 byte dropped", 64'(done), 64'd0);
        send_tuple(8'h30, 8'd0, 0, 128'h0);     // R2 tuple without data
        send_tuple(8'h80, 8'd2, 2, 128'h5A_00);
        send_byte(8'hFF, 1'b0);
        chk("R2 after empty tuple", 64'(srom_rev), 64'h5A);
        chk("R11 done after restart", 64'(done), 64'd1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failed++;
        tests++;
        $display("FAIL watchdog R2 actual=hung expected=finished");
        $display("  [TB] %0d tests run, %0d failed", tests, failed);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_defaults();
        t_good_chain();
        t_mac_rule();
        t_bad_size(8'h00, 8'd3, 3, 128'h02_01_00, 4'd2);
        t_bad_size(8'h01, 8'd6, 6, 128'h05_04_03_02_01_00, 4'd3);
        t_bad_size(8'h03, 8'd8, 8, 128'h07_06_05_04_03_02_01_00, 4'd5);
        t_bad_size(8'h07, 8'd1, 1, 128'h00, 4'd9);
        t_bad_size(8'h08, 8'd4, 4, 128'h03_02_01_00, 4'd10);
        t_bad_size(8'h09, 8'd4, 4, 128'h03_02_01_00, 4'd11);
        t_fail_on_last();
        t_start_collide();
        $display("  [TB] %0d tests run, %0d failed", tests, failed);
        $finish;
    end
endmodule